// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds the 8-bit control word that steers a chip's clock generator. Software writes it over a simple bus port. The block decodes the word into side-effect outputs: a clock-output pin selector, a peripheral-clock stop flag, the sub-oscillator drive strength, the sub-oscillator port enable, a main-oscillator stop, the watchdog action and the CPU clock source. The oscillators, the clock divider and the clock muxes sit outside the block and consume these outputs.

Two inputs guard writes. A protect-enable input must be high for any write to land. A clock-change lock input freezes the three bits that could disturb the running clock. The watchdog action bit can be set but not cleared. A bit-7 change in the same write as a bit-4 or bit-5 change is refused for bit 7 only, and this sets a sticky error flag. Raising the main-oscillator stop bit sends the divider a one-cycle load strobe together with the divide-by-8 code. A stop-mode entry strobe forces the sub-oscillator drive to high.

Top module: `sysclk_ctrl_reg`

## Requirements
- R1: After an active-low asynchronous reset, the register reads 0x08, `seq_err_o` is 0 and `div_load_o` is 0.
- R2: Each output mirrors its register bit: `clkout_sel_o` is bits [1:0] (00 port, 01 fC, 10 f8, 11 f32), `periph_stop_o` is bit 2, `sub_drive_hi_o` is bit 3, `sub_port_en_o` is bit 4, `main_osc_stop_o` is bit 5, `wdt_rst_sel_o` is bit 6 and `cpu_sub_sel_o` is bit 7.
- R3: A write with `prot_en_i` low leaves the register unchanged.
- R4: Bit 6 is set-only. Once it is 1, a write of 0 keeps it at 1 until reset.
- R5: While `clk_lock_i` is 1, bits 2, 5 and 7 keep their values when written. The other bits still take the written data.
- R6: When bit 5 goes from 0 to 1, `div_load_o` is high for exactly one cycle, the cycle in which bit 5 first reads 1. During that cycle `div_load_val_o` is 5'b01000.
- R7: No `div_load_o` pulse is produced if `ocm_mode_i` is 1 at the clock edge where bit 5 rises.
- R8: A `stop_entry_i` pulse sets bit 3 to 1 at the next edge, whatever the state of `prot_en_i`. It also overrides a write of 0 to bit 3 in the same cycle.
- R9: If a write would change bit 7 and would also change bit 4 or bit 5, bit 7 keeps its old value, bits 4 and 5 are updated, and `seq_err_o` goes to 1 and stays there until reset.
- R10: `rd_data_o` always shows the current register value, including while writes are unprotected or locked.
- R11: A write that changes bit 7 while bits 4 and 5 stay the same updates bit 7 and leaves `seq_err_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | 8 | Bus write data |
| prot_en_i | input | 1 | Write enable from the protect register |
| clk_lock_i | input | 1 | Freezes bits 2, 5 and 7 |
| stop_entry_i | input | 1 | Stop-mode entry strobe |
| ocm_mode_i | input | 1 | On-chip oscillator mode is active |
| rd_data_o | output | 8 | Current register value |
| clkout_sel_o | output | 2 | Clock-output pin function |
| periph_stop_o | output | 1 | Peripheral clock stops in wait mode |
| sub_drive_hi_o | output | 1 | Sub-oscillator high drive |
| sub_port_en_o | output | 1 | Sub-oscillator pins in oscillator function |
| main_osc_stop_o | output | 1 | Main oscillator stop |
| wdt_rst_sel_o | output | 1 | Watchdog causes reset instead of interrupt |
| cpu_sub_sel_o | output | 1 | CPU runs from the sub clock |
| div_load_o | output | 1 | One-cycle divider load strobe |
| div_load_val_o | output | 5 | Divider code loaded by the strobe (divide-by-8) |
| seq_err_o | output | 1 | Sticky bit-7 sequencing error |

## Verification
The assertions take all inputs to be synchronous to `clk_i`. They also take `stop_entry_i` to be the only source of bit-3 changes outside a protected write. The stability properties are therefore guarded on the absence of both a protected write and a stop strobe. The directed tasks drive every input on the falling edge and hold it for one full cycle, so each write and strobe is seen at exactly one rising edge. The `ocm_mode_i` and lock levels are set up before the write they qualify.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int REG_W   = 8;
  localparam int DIV_W   = 5;
  localparam int B_PSTOP = 2;
  localparam int B_DRV   = 3;
  localparam int B_PORT  = 4;
  localparam int B_MSTOP = 5;
  localparam int B_WDT   = 6;
  localparam int B_CPU   = 7;
  localparam logic [REG_W-1:0] RST_VAL   = 8'h08;
  localparam logic [REG_W-1:0] LOCK_MASK = (REG_W'(1) << B_PSTOP) | (REG_W'(1) << B_MSTOP)
                                         | (REG_W'(1) << B_CPU);
  localparam logic [DIV_W-1:0] DIV8_CODE = 5'b01000;
endpackage

// File: rtl/sysclk_wr_filter.sv
module sysclk_wr_filter
  import sysclk_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] cur_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         prot_en_i,
  input  logic         lock_i,
  input  logic         stop_i,
  output logic [W-1:0] nxt_o,
  output logic         seq_viol_o
);
  logic         wr_ok;
  logic [W-1:0] wmask, cand, merged, wr_val;
  logic         side_chg, cpu_chg;

  assign wr_ok = wr_en_i & prot_en_i;
  assign wmask = lock_i ? ~LOCK_MASK : {W{1'b1}};
  assign cand  = (cur_i & ~wmask) | (wr_data_i & wmask);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == B_WDT) begin : g_set_only
      assign merged[i] = cur_i[i] | cand[i];
    end else begin : g_plain
      assign merged[i] = cand[i];
    end
  end

  assign side_chg   = (cand[B_PORT] ^ cur_i[B_PORT]) | (cand[B_MSTOP] ^ cur_i[B_MSTOP]);
  assign cpu_chg    = cand[B_CPU] ^ cur_i[B_CPU];
  assign seq_viol_o = wr_ok & cpu_chg & side_chg;

  always_comb begin
    wr_val = merged;
    if (seq_viol_o) wr_val[B_CPU] = cur_i[B_CPU];
    nxt_o = wr_ok ? wr_val : cur_i;
    if (stop_i) nxt_o[B_DRV] = 1'b1;
  end
endmodule

// File: rtl/sysclk_div_strobe.sv
module sysclk_div_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_cur_i,
  input  logic stop_nxt_i,
  input  logic ocm_mode_i,
  output logic load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_o <= 1'b0;
    else         load_o <= stop_nxt_i & ~stop_cur_i & ~ocm_mode_i;
  end
endmodule

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg
  import sysclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             prot_en_i,
  input  logic             clk_lock_i,
  input  logic             stop_entry_i,
  input  logic             ocm_mode_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [1:0]       clkout_sel_o,
  output logic             periph_stop_o,
  output logic             sub_drive_hi_o,
  output logic             sub_port_en_o,
  output logic             main_osc_stop_o,
  output logic             wdt_rst_sel_o,
  output logic             cpu_sub_sel_o,
  output logic             div_load_o,
  output logic [DIV_W-1:0] div_load_val_o,
  output logic             seq_err_o
);
  logic [REG_W-1:0] reg_q, reg_d;
  logic             seq_viol, seq_err_q;

  sysclk_wr_filter #(.W(REG_W)) u_filter (
    .cur_i      (reg_q),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .prot_en_i  (prot_en_i),
    .lock_i     (clk_lock_i),
    .stop_i     (stop_entry_i),
    .nxt_o      (reg_d),
    .seq_viol_o (seq_viol)
  );

  sysclk_div_strobe u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_cur_i (reg_q[B_MSTOP]),
    .stop_nxt_i (reg_d[B_MSTOP]),
    .ocm_mode_i (ocm_mode_i),
    .load_o     (div_load_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q     <= RST_VAL;
      seq_err_q <= 1'b0;
    end else begin
      reg_q     <= reg_d;
      seq_err_q <= seq_err_q | seq_viol;
    end
  end

  assign rd_data_o       = reg_q;
  assign clkout_sel_o    = reg_q[1:0];
  assign periph_stop_o   = reg_q[B_PSTOP];
  assign sub_drive_hi_o  = reg_q[B_DRV];
  assign sub_port_en_o   = reg_q[B_PORT];
  assign main_osc_stop_o = reg_q[B_MSTOP];
  assign wdt_rst_sel_o   = reg_q[B_WDT];
  assign cpu_sub_sel_o   = reg_q[B_CPU];
  assign div_load_val_o  = DIV8_CODE;
  assign seq_err_o       = seq_err_q;
endmodule

// File: rtl/sysclk_ctrl_reg_chk.sv
module sysclk_ctrl_reg_chk
  import sysclk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             prot_en_i,
  input logic             clk_lock_i,
  input logic             stop_entry_i,
  input logic             ocm_mode_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             div_load_o,
  input logic             seq_err_o
);
  assert_no_unprot_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && prot_en_i) && !stop_entry_i) |=> $stable(rd_data_o));

  assert_wdt_set_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_WDT] |=> rd_data_o[B_WDT]);

  assert_lock_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_lock_i |=> (rd_data_o[B_PSTOP] == $past(rd_data_o[B_PSTOP]) &&
                    rd_data_o[B_MSTOP] == $past(rd_data_o[B_MSTOP]) &&
                    rd_data_o[B_CPU]   == $past(rd_data_o[B_CPU])));

  assert_strobe_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_load_o |=> !div_load_o);

  assert_strobe_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_load_o |-> (rd_data_o[B_MSTOP] && !$past(rd_data_o[B_MSTOP])));

  assert_strobe_ocm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_load_o |-> !$past(ocm_mode_i));

  assert_stop_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_entry_i |=> rd_data_o[B_DRV]);

  assert_seq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |=> seq_err_o);

  assert_seq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_err_o) |-> (rd_data_o[B_CPU] == $past(rd_data_o[B_CPU])));
endmodule

bind sysclk_ctrl_reg sysclk_ctrl_reg_chk chk_i (.*);

// File: tb/sysclk_ctrl_reg_tb_top.sv
module sysclk_ctrl_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       prot_en_i = 1'b0;
  logic       clk_lock_i = 1'b0;
  logic       stop_entry_i = 1'b0;
  logic       ocm_mode_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [1:0] clkout_sel_o;
  logic       periph_stop_o, sub_drive_hi_o, sub_port_en_o, main_osc_stop_o;
  logic       wdt_rst_sel_o, cpu_sub_sel_o, div_load_o, seq_err_o;
  logic [4:0] div_load_val_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sysclk_ctrl_reg dut_i (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 0; prot_en_i = 0; clk_lock_i = 0; stop_entry_i = 0; ocm_mode_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // drive for one edge, return at the following falling edge
  task automatic do_write(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(rd_data_o == 8'h08, "R1 rd", rd_data_o, 8'h08);
    chk(!seq_err_o && !div_load_o, "R1 flags", {seq_err_o, div_load_o}, 0);
  endtask

  task automatic t_decode();
    do_reset();
    prot_en_i = 1;
    for (int c = 0; c < 4; c++) begin
      do_write(8'(c));
      chk(clkout_sel_o == 2'(c), "R2 clkout", clkout_sel_o, c);
    end
    do_write(8'h1C);
    chk({cpu_sub_sel_o, wdt_rst_sel_o, main_osc_stop_o, sub_port_en_o, sub_drive_hi_o,
         periph_stop_o} == 6'b000111, "R2 bits", rd_data_o, 8'h1C);
  endtask

  task automatic t_protect();
    do_reset();
    prot_en_i = 0;
    do_write(8'hFF);
    chk(rd_data_o == 8'h08, "R3 ignored", rd_data_o, 8'h08);
    chk(!div_load_o, "R3 no strobe", div_load_o, 0);
  endtask

  task automatic t_wdt();
    do_reset();
    prot_en_i = 1;
    do_write(8'h40);
    chk(wdt_rst_sel_o == 1, "R4 set", rd_data_o, 8'h40);
    do_write(8'h00);
    chk(rd_data_o == 8'h40, "R4 no clear", rd_data_o, 8'h40);
  endtask

  task automatic t_lock();
    do_reset();
    prot_en_i = 1; clk_lock_i = 1;
    do_write(8'hFF);
    chk(rd_data_o == 8'h5B, "R5 R10 locked", rd_data_o, 8'h5B);
    chk(!div_load_o, "R5 no strobe", div_load_o, 0);
    clk_lock_i = 0;
  endtask

  task automatic t_strobe();
    do_reset();
    prot_en_i = 1;
    do_write(8'h28);
    chk(div_load_o && div_load_val_o == 5'b01000, "R6 strobe",
        {div_load_o, div_load_val_o}, 6'h28);
    chk(rd_data_o == 8'h28, "R6 rd", rd_data_o, 8'h28);
    @(negedge clk_i);
    chk(!div_load_o, "R6 width", div_load_o, 0);
  endtask

  task automatic t_ocm();
    do_reset();
    prot_en_i = 1; ocm_mode_i = 1;
    do_write(8'h28);
    chk(!div_load_o, "R7 suppressed", div_load_o, 0);
    chk(rd_data_o == 8'h28, "R7 rd", rd_data_o, 8'h28);
    ocm_mode_i = 0;
  endtask

  task automatic t_stop();
    do_reset();
    prot_en_i = 1;
    do_write(8'h00);
    chk(rd_data_o == 8'h00, "R8 cleared", rd_data_o, 8'h00);
    prot_en_i = 0; stop_entry_i = 1;
    @(negedge clk_i); stop_entry_i = 0;
    chk(rd_data_o == 8'h08, "R8 unprotected", rd_data_o, 8'h08);
    prot_en_i = 1; stop_entry_i = 1;
    do_write(8'h01);
    stop_entry_i = 0;
    chk(rd_data_o == 8'h09, "R8 priority", rd_data_o, 8'h09);
  endtask

  task automatic t_seq();
    do_reset();
    prot_en_i = 1;
    do_write(8'h90);
    chk(rd_data_o == 8'h10, "R9 bit7 held", rd_data_o, 8'h10);
    chk(seq_err_o, "R9 flag", seq_err_o, 1);
    do_write(8'h90);
    chk(rd_data_o == 8'h90, "R11 alone", rd_data_o, 8'h90);
    chk(seq_err_o, "R9 sticky", seq_err_o, 1);
    do_reset();
    prot_en_i = 1;
    do_write(8'hA8);
    chk(rd_data_o == 8'h28, "R9 bit5 case", rd_data_o, 8'h28);
    chk(seq_err_o && div_load_o, "R9 flag+strobe", {seq_err_o, div_load_o}, 3);
    do_reset();
    prot_en_i = 1;
    do_write(8'h88);
    chk(rd_data_o == 8'h88 && !seq_err_o, "R11 clean", {seq_err_o, rd_data_o}, 8'h88);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_decode(); t_protect(); t_wdt(); t_lock();
        t_strobe(); t_ocm(); t_stop(); t_seq();
      end
      begin
        repeat (WD_CYCLES) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule